// File: doc/BRIEF.md
# Address-Decoded Wait-State Generator

This block stretches single processor bus cycles so that slow devices have time to respond. When a cycle begins, it decodes the address and the memory/I-O select line into one of several target regions. It drives that region's chip select for the whole cycle. It then holds a not-ready request toward the processor for the number of extra clock periods configured for that region. After the last extra period it marks the end of the cycle with a one-clock completion pulse.

Every bus cycle takes at least one clock, which is the base access. Each wait state adds one full clock period of device time. Part of every access is lost to decoding and buffering. For this reason, the count that each region holds after reset is the smallest count for which the base period plus the extra periods, less that overhead, covers the device's access time. Software-free configuration inputs can replace any region's count while the bus is idle.

Top module: `wait_state_gen`

## Requirements
- R1: With `memSel`=1, the region is the top two address bits: `addr[19:18]` equal to 0..3 selects regions 0..3, and `chipSel` bit k is set for region k.
- R2: With `memSel`=0 (I/O space), only the low 16 address bits count. `addr[15]`=0 selects region 4 and `addr[15]`=1 selects region 5. Bits 19:16 have no effect on the choice.
- R3: `chipSel` is all zero while idle. During a cycle it has exactly one bit set, and that bit does not change from the clock after the start until the completion clock.
- R4: A `cycleStart` sampled high while idle begins a cycle. For a region count n, `waitReq` is high for exactly the n clocks that follow the start edge.
- R5: `cycleDone` is high for exactly one clock, directly after the wait clocks. With n=0 it comes in the first clock after the start edge. The block is idle in the clock after that.
- R6: A `cycleStart` that arrives while a cycle is in progress, including on its completion clock, is ignored. It starts no cycle and changes neither the chip select nor the timing.
- R7: After reset, the counts for regions 0..5 are 0, 1, 3, 5, 3, 7. These come from device access times of 10, 30, 60, 100, 70 and 150 ns, a 20 ns clock and 10 ns of overhead, with the count capped at 7.
- R8: `cfgWe` while idle writes `cfgWaits` into the region numbered `cfgIdx`, using the numbering of R1/R2, and the next cycle to that region uses it. `cfgWe` during a cycle is ignored.
- R9: Reset leaves the block idle with `waitReq`, `cycleDone` and `chipSel` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cycleStart | input | 1 | Request to begin a bus cycle |
| addr | input | 20 | Bus address |
| memSel | input | 1 | 1 = memory space, 0 = I/O space |
| cfgWe | input | 1 | Write strobe for a region wait count |
| cfgIdx | input | 3 | Region number to write |
| cfgWaits | input | 3 | New wait count, 0..7 |
| waitReq | output | 1 | Not-ready request to the processor |
| cycleDone | output | 1 | One-clock completion pulse |
| chipSel | output | 6 | One-hot region select, held during a cycle |

## Verification
The hardest case to create from the ports is a new start request that lands exactly on the completion clock. At that edge the controller is leaving its busy state, so a careless design would treat the request as a fresh cycle. The directed cycle task can raise `cycleStart`, together with a different address and space, on any chosen clock inside a cycle, including the completion clock. It then checks that the block returns to idle with no chip select. The same task can pulse a configuration write in mid-cycle, and the following cycle to that region shows whether the write was wrongly taken.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef struct packed {
    logic load;    // capture region and count at cycle start
    logic dec;     // count one wait clock off
    logic finish;  // completion clock: release chip select
    logic cfgOk;   // configuration writes permitted
  } wsStrobe_t;

  // smallest n with (n+1)*clk - overhead >= device time, capped at maxN
  function automatic int unsigned waitsFor(input int unsigned devNs,
                                           input int unsigned clkNs,
                                           input int unsigned ovhNs,
                                           input int unsigned maxN);
    int unsigned n;
    n = 0;
    while (n < maxN && (n + 1) * clkNs < devNs + ovhNs) n++;
    return n;
  endfunction

endpackage

// File: rtl/ws_decode.sv
module ws_decode #(
  parameter int ADDR_W       = 20,
  parameter int MEM_SEL_BITS = 2,
  parameter int IO_SEL_BITS  = 1,
  parameter int IO_ADDR_W    = 16,
  localparam int NUM_MEM     = 2 ** MEM_SEL_BITS,
  localparam int NUM_REGIONS = NUM_MEM + 2 ** IO_SEL_BITS,
  localparam int REG_W       = $clog2(NUM_REGIONS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              memSel,
  output logic [REG_W-1:0]  regionIdx
);
  logic [MEM_SEL_BITS-1:0] memField;
  logic [IO_SEL_BITS-1:0]  ioField;

  assign memField = addr[ADDR_W-1 -: MEM_SEL_BITS];
  assign ioField  = addr[IO_ADDR_W-1 -: IO_SEL_BITS];

  always_comb begin
    if (memSel) regionIdx = REG_W'(memField);
    else        regionIdx = REG_W'(NUM_MEM) + REG_W'(ioField);
  end

  always_comb begin
    if (!$isunknown(regionIdx))
      a_r2_index_in_range: assert (int'(regionIdx) < NUM_REGIONS);
  end
endmodule

// File: rtl/ws_control.sv
module ws_control
  import ws_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cycleStart,
  input  logic      cntZero,
  output wsStrobe_t st,
  output logic      waitReq,
  output logic      cycleDone
);
  typedef enum logic {S_IDLE, S_BUSY} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else if (st.load) state <= S_BUSY;
    else if (st.finish) state <= S_IDLE;
  end

  always_comb begin
    st.load   = (state == S_IDLE) && cycleStart;
    st.dec    = (state == S_BUSY) && !cntZero;
    st.finish = (state == S_BUSY) && cntZero;
    st.cfgOk  = (state == S_IDLE);
  end

  assign waitReq   = st.dec;
  assign cycleDone = st.finish;

  a_r4_wait_not_with_done: assert property (@(posedge clk) disable iff (rst)
    !(waitReq && cycleDone));
  a_r5_done_one_clock: assert property (@(posedge clk) disable iff (rst)
    cycleDone |=> !cycleDone);
  a_r6_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
    (waitReq && cycleStart) |=> (waitReq || cycleDone));
  a_r5_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    cycleDone |=> st.cfgOk);
endmodule

// File: rtl/ws_datapath.sv
module ws_datapath
  import ws_pkg::*;
#(
  parameter int NUM_REGIONS = 6,
  parameter int WAIT_W      = 3,
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned OVH_NS = 10,
  parameter int unsigned DEV_NS [NUM_REGIONS] = '{10, 30, 60, 100, 70, 150},
  localparam int REG_W = $clog2(NUM_REGIONS),
  localparam int unsigned MAX_N = (1 << WAIT_W) - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  wsStrobe_t              st,
  input  logic [REG_W-1:0]       regionIdx,
  input  logic                   cfgWe,
  input  logic [REG_W-1:0]       cfgIdx,
  input  logic [WAIT_W-1:0]      cfgWaits,
  output logic                   cntZero,
  output logic [NUM_REGIONS-1:0] csOut
);
  logic [NUM_REGIONS-1:0][WAIT_W-1:0] waitTable;
  logic [WAIT_W-1:0]                  cnt;
  logic [NUM_REGIONS-1:0]             csQ;
  logic                               cfgAccept;

  assign cfgAccept = cfgWe && st.cfgOk;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    localparam logic [WAIT_W-1:0] DEF_N =
      WAIT_W'(waitsFor(DEV_NS[g], CLK_NS, OVH_NS, MAX_N));
    always_ff @(posedge clk) begin
      if (rst) waitTable[g] <= DEF_N;
      else if (cfgAccept && int'(cfgIdx) == g) waitTable[g] <= cfgWaits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      csQ <= '0;
    end else if (st.load) begin
      cnt <= waitTable[regionIdx];
      csQ <= NUM_REGIONS'(1) << regionIdx;
    end else if (st.dec) begin
      cnt <= cnt - 1'b1;
    end else if (st.finish) begin
      csQ <= '0;
    end
  end

  assign cntZero = (cnt == '0);
  assign csOut   = csQ;

  a_r3_cs_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(csOut));
  a_r3_cs_held: assert property (@(posedge clk) disable iff (rst)
    st.dec |=> $stable(csOut) && csOut != '0);
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    st.dec |=> cnt == WAIT_W'($past(cnt) - 1'b1));
  a_r8_cfg_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfgWe && !st.cfgOk) |=> $stable(waitTable));
  a_r3_cs_clear_idle: assert property (@(posedge clk) disable iff (rst)
    st.finish |=> csOut == '0);
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import ws_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int MEM_SEL_BITS = 2,
  parameter int IO_SEL_BITS  = 1,
  parameter int IO_ADDR_W    = 16,
  parameter int WAIT_W       = 3,
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned OVH_NS = 10,
  parameter int unsigned DEV_NS [2 ** MEM_SEL_BITS + 2 ** IO_SEL_BITS] =
    '{10, 30, 60, 100, 70, 150},
  localparam int NUM_REGIONS = 2 ** MEM_SEL_BITS + 2 ** IO_SEL_BITS,
  localparam int REG_W       = $clog2(NUM_REGIONS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cycleStart,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   memSel,
  input  logic                   cfgWe,
  input  logic [REG_W-1:0]       cfgIdx,
  input  logic [WAIT_W-1:0]      cfgWaits,
  output logic                   waitReq,
  output logic                   cycleDone,
  output logic [NUM_REGIONS-1:0] chipSel
);
  wsStrobe_t        st;
  logic             cntZero;
  logic [REG_W-1:0] regionIdx;

  ws_decode #(
    .ADDR_W(ADDR_W), .MEM_SEL_BITS(MEM_SEL_BITS),
    .IO_SEL_BITS(IO_SEL_BITS), .IO_ADDR_W(IO_ADDR_W)
  ) u_decode (
    .addr(addr), .memSel(memSel), .regionIdx(regionIdx)
  );

  ws_control u_control (
    .clk(clk), .rst(rst), .cycleStart(cycleStart), .cntZero(cntZero),
    .st(st), .waitReq(waitReq), .cycleDone(cycleDone)
  );

  ws_datapath #(
    .NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W),
    .CLK_NS(CLK_NS), .OVH_NS(OVH_NS), .DEV_NS(DEV_NS)
  ) u_datapath (
    .clk(clk), .rst(rst), .st(st), .regionIdx(regionIdx),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgWaits(cfgWaits),
    .cntZero(cntZero), .csOut(chipSel)
  );
endmodule

// File: tb/sim_wait_state_gen.sv
module sim_wait_state_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cycleStart = 1'b0;
  logic [19:0] addr = '0;
  logic       memSel = 1'b1;
  logic       cfgWe = 1'b0;
  logic [2:0] cfgIdx = '0;
  logic [2:0] cfgWaits = '0;
  logic       waitReq, cycleDone;
  logic [5:0] chipSel;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  wait_state_gen u0 (
    .clk(clk), .rst(rst), .cycleStart(cycleStart), .addr(addr),
    .memSel(memSel), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgWaits(cfgWaits),
    .waitReq(waitReq), .cycleDone(cycleDone), .chipSel(chipSel)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleCheck(input string tag);
    chk(chipSel == 6'd0, {tag, " chipSel idle"}, chipSel, 0);
    chk(!waitReq, {tag, " waitReq idle"}, waitReq, 0);
    chk(!cycleDone, {tag, " cycleDone idle"}, cycleDone, 0);
  endtask

  // one bus cycle; optional stray start at clock glitchAt, optional
  // config write at clock cfgAt (both measured from the start edge)
  task automatic busCycle(input logic [19:0] a, input logic m, input int region,
                          input int n, input string tag,
                          input int glitchAt = -1, input int cfgAt = -1,
                          input logic [2:0] cIdx = 0, input logic [2:0] cVal = 0);
    @(negedge clk);
    addr = a; memSel = m; cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    for (int k = 0; k <= n; k++) begin
      chk(waitReq == (k < n), {tag, " R4 waitReq"}, waitReq, k < n);
      chk(cycleDone == (k == n), {tag, " R5 cycleDone"}, cycleDone, k == n);
      chk(chipSel == 6'(1 << region), {tag, " R3 chipSel"}, chipSel, 1 << region);
      if (k == glitchAt) begin
        cycleStart = 1'b1; addr = ~a; memSel = ~m;
      end
      if (k == cfgAt) begin
        cfgWe = 1'b1; cfgIdx = cIdx; cfgWaits = cVal;
      end
      @(negedge clk);
      cycleStart = 1'b0; addr = a; memSel = m; cfgWe = 1'b0;
    end
    idleCheck({tag, " R5 back to idle"});
  endtask

  task automatic cfgWrite(input logic [2:0] idx, input logic [2:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgWaits = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic testReset;
    repeat (3) @(negedge clk);
    idleCheck("R9 in reset");
    rst = 1'b0;
    @(negedge clk);
    idleCheck("R9 after reset");
  endtask

  task automatic testDefaults;
    busCycle(20'h0_1234, 1'b1, 0, 0, "R1 R7 region0");
    busCycle(20'h4_0000, 1'b1, 1, 1, "R1 R7 region1");
    busCycle(20'h8_1234, 1'b1, 2, 3, "R1 R7 region2");
    busCycle(20'hC_FFFF, 1'b1, 3, 5, "R1 R7 region3");
    busCycle(20'h0_0100, 1'b0, 4, 3, "R2 R7 region4");
    busCycle(20'h0_8100, 1'b0, 5, 7, "R2 R7 region5");
  endtask

  task automatic testIoUpperBits;
    busCycle(20'hF_0123, 1'b0, 4, 3, "R2 upper bits ignored io0");
    busCycle(20'hC_F000, 1'b0, 5, 7, "R2 upper bits ignored io1");
  endtask

  task automatic testIgnoreStart;
    busCycle(20'h8_0000, 1'b1, 2, 3, "R6 start mid wait", 1);
    busCycle(20'h8_0000, 1'b1, 2, 3, "R6 start on done clock", 3);
    busCycle(20'h0_0000, 1'b1, 0, 0, "R6 start on zero-wait done", 0);
  endtask

  task automatic testConfig;
    cfgWrite(3'd3, 3'd2);
    busCycle(20'hC_0000, 1'b1, 3, 2, "R8 idle write region3");
    cfgWrite(3'd0, 3'd7);
    busCycle(20'h0_0004, 1'b1, 0, 7, "R8 idle write region0 max");
    cfgWrite(3'd5, 3'd0);
    busCycle(20'h0_8000, 1'b0, 5, 0, "R8 idle write region5 zero");
    busCycle(20'h4_0000, 1'b1, 1, 1, "R8 busy write issued", -1, 0, 3'd1, 3'd6);
    busCycle(20'h4_0000, 1'b1, 1, 1, "R8 busy write ignored");
  endtask

  initial begin
    testReset();
    testDefaults();
    testIoUpperBits();
    testIgnoreStart();
    testConfig();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule